// File: doc/BRIEF.md
# Bitstream configuration loader

This block sits between a host bus and the configuration port of a target FPGA. The host first loads the number of bytes in the bitstream while the engine is idle, then turns the engine on. After that it sends the image as 32-bit words to a single data-port address. The words go into a small FIFO. The block drains them to the target one word per valid/ready handshake and stops once the programmed byte total has gone out.

There are two ways to feed the FIFO. In CPU mode the host writes a block of words and polls the fill level until it reads zero. In DMA mode the block drives a request line that an external DMA engine follows; the request stays up only while at least half the FIFO is free, so each burst can move half a FIFO. The block raises an interrupt when the target reports completion after the full count, and also when any error is flagged. Writing zero to the control register stops the engine, empties the FIFO and clears the interrupt. A separate control bit holds the target's active-low configuration line low, so writing that bit and then zero gives a reset pulse.

Top module: `cfg_loader`

## Requirements
- R1: After reset, control and status read 0, FIFO-size (0x48) reads FIFO depth times 4, FIFO-used (0x4C) reads 0, and `irq`, `dma_req` and `tgt_valid` are low while `tgt_cfg_n` is high.
- R2: A write to the data port (0x3000) while control bit 0 (enable) is clear is discarded: FIFO-used stays 0 and nothing is presented to the target.
- R3: While enabled, words leave on `tgt_data` in the order they were written. `tgt_valid` is high only when the FIFO holds data and the current byte count (0x54) is below the total (0x50). The current count grows by 4 per accepted word.
- R4: The total byte count register (0x50) takes writes only while enable is clear; a write while enabled leaves it unchanged.
- R5: FIFO-used reads the bytes held (words times 4). A data-port write while the FIFO is full is dropped and sets status bit 2 (overflow).
- R6: When enabled, not in reset, the current count equals the total and `tgt_done` is high, status bit 18 (done) sets and `irq` goes high.
- R7: When enabled, `tgt_err` high latches status bit 1 and raises `irq`. Bits 15:1 of status are the error flags; bit 0 mirrors enable.
- R8: Writing zero to control (0x40) clears `irq`. Any control write with bit 0 clear empties the FIFO.
- R9: Control bit 1 drives `tgt_cfg_n` low while set and clears the done flag.
- R10: `dma_req` is high exactly when enable and control bit 2 (DMA mode) are set, free FIFO space is at least half the depth, and the bytes accepted since enable are below the total.
- R11: A control write that sets enable while it was clear zeroes the current count, the accepted count and the done, error and overflow flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register or data-port write strobe |
| bus_addr | input | AW | Byte address for both reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| dma_req | output | 1 | Request to the external DMA engine |
| irq | output | 1 | Interrupt, completion or error |
| tgt_cfg_n | output | 1 | Active-low configuration reset to the target |
| tgt_data | output | 32 | Configuration word to the target |
| tgt_valid | output | 1 | `tgt_data` is valid |
| tgt_ready | input | 1 | Target accepts the word this cycle |
| tgt_done | input | 1 | Target reports configuration complete |
| tgt_err | input | 1 | Target reports a configuration error |

## Verification
The DMA request depends on two limits at once: free space in the FIFO and bytes accepted against the total. The hardest case to reach is the request dropping for the first reason and then coming back. The stimulus holds `tgt_ready` low while it pushes just past half the FIFO, which takes the request down. It then lets the target drain the FIFO, which brings the request back. It then pushes exactly enough words to reach the total, so the byte limit alone takes the request down. Overflow is reached the same way: the target is held off while one more word than the depth is pushed.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int DEPTH = 16,
  parameter int AW    = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          dma_req,
  output logic          irq,
  output logic          tgt_cfg_n,
  output logic [31:0]   tgt_data,
  output logic          tgt_valid,
  input  logic          tgt_ready,
  input  logic          tgt_done,
  input  logic          tgt_err
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [AW-1:0] A_CTRL  = AW'('h40);
  localparam logic [AW-1:0] A_STAT  = AW'('h44);
  localparam logic [AW-1:0] A_SIZE  = AW'('h48);
  localparam logic [AW-1:0] A_USED  = AW'('h4C);
  localparam logic [AW-1:0] A_TOTAL = AW'('h50);
  localparam logic [AW-1:0] A_CUR   = AW'('h54);
  localparam logic [AW-1:0] A_DATA  = AW'('h3000);
  localparam logic [PW:0]   CAP     = (PW+1)'(DEPTH);
  localparam logic [PW:0]   HALF    = (PW+1)'(DEPTH / 2);

  logic          en, rst_bit, dma_mode, done, err, ovf;
  logic [31:0]   total, cur, acc;
  logic [31:0]   mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW:0]   count;

  wire ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  wire data_wr = bus_wr && (bus_addr == A_DATA);
  wire full    = (count == CAP);
  wire push    = data_wr && en && !full;
  wire pop     = tgt_valid && tgt_ready && !ctrl_wr;
  wire live    = en && !ctrl_wr;

  assign tgt_valid = en && (count != '0) && (cur < total);
  assign tgt_data  = mem[rp];
  assign tgt_cfg_n = !rst_bit;
  assign dma_req   = en && dma_mode && ((CAP - count) >= HALF) && (acc < total);

  always_ff @(posedge clk)
    if (push) mem[wp] <= bus_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en <= 1'b0; rst_bit <= 1'b0; dma_mode <= 1'b0;
      done <= 1'b0; err <= 1'b0; ovf <= 1'b0; irq <= 1'b0;
      total <= '0; cur <= '0; acc <= '0;
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (live && tgt_err) begin
        err <= 1'b1; irq <= 1'b1;
      end
      if (live && !rst_bit && (cur == total) && tgt_done) begin
        done <= 1'b1; irq <= 1'b1;
      end
      if (rst_bit) done <= 1'b0;
      if (pop) cur <= cur + 32'd4;
      if (data_wr && en && full) begin
        ovf <= 1'b1; irq <= 1'b1;
      end
      if (push) acc <= acc + 32'd4;
      if (bus_wr && bus_addr == A_TOTAL && !en) total <= bus_wdata;
      wp    <= wp + PW'(push);
      rp    <= rp + PW'(pop);
      count <= count + (PW+1)'(push) - (PW+1)'(pop);
      if (ctrl_wr) begin
        en <= bus_wdata[0]; rst_bit <= bus_wdata[1]; dma_mode <= bus_wdata[2];
        if (bus_wdata[0] && !en) begin
          cur <= '0; acc <= '0; err <= 1'b0; ovf <= 1'b0; done <= 1'b0;
        end
        if (bus_wdata[2:0] == 3'b000) irq <= 1'b0;
        if (!bus_wdata[0]) begin
          wp <= '0; rp <= '0; count <= '0;
        end
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {29'd0, dma_mode, rst_bit, en};
      A_STAT:  bus_rdata = {13'd0, done, 15'd0, ovf, err, en};
      A_SIZE:  bus_rdata = 32'(DEPTH) << 2;
      A_USED:  bus_rdata = 32'(count) << 2;
      A_TOTAL: bus_rdata = total;
      A_CUR:   bus_rdata = cur;
      default: bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/cfg_loader_chk.sv
module cfg_loader_chk #(
  parameter int DEPTH = 16,
  parameter int AW    = 14
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     bus_wr,
  input logic [AW-1:0]            bus_addr,
  input logic [31:0]              bus_wdata,
  input logic                     en,
  input logic                     dma_mode,
  input logic                     done,
  input logic [31:0]              cur,
  input logic [$clog2(DEPTH):0]   count,
  input logic                     tgt_valid,
  input logic                     tgt_ready,
  input logic                     dma_req,
  input logic                     irq
);
  wire cw = bus_wr && (bus_addr == AW'('h40));

  AST_VALID_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_valid |-> en);  // R3
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_valid && tgt_ready && !cw) |=> (cur == $past(cur) + 32'd4));  // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= ($clog2(DEPTH)+1)'(DEPTH));  // R5
  AST_IDLE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (count == '0));  // R2
  AST_REQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (en && dma_mode));  // R10
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(cw && bus_wdata[2:0] == 3'b000));  // R8
  AST_DONE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> irq);  // R6
endmodule

bind cfg_loader cfg_loader_chk #(.DEPTH(DEPTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .en(en), .dma_mode(dma_mode), .done(done),
  .cur(cur), .count(count), .tgt_valid(tgt_valid), .tgt_ready(tgt_ready),
  .dma_req(dma_req), .irq(irq)
);

// File: tb/cfg_loader_test.sv
module cfg_loader_test;
  localparam int DEPTH = 16;
  localparam int AW = 14;

  logic clk = 0, rst_n = 0;
  logic bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, tgt_data;
  logic dma_req, irq, tgt_cfg_n, tgt_valid;
  logic tgt_ready = 0, tgt_done = 0, tgt_err = 0;
  int errors = 0, checks = 0;
  bit finished = 0;

  cfg_loader #(.DEPTH(DEPTH), .AW(AW)) uut (.*);

  always #2.5 clk = ~clk;

  // behavioural reference model
  logic [31:0] q[$];
  bit m_en, m_rst, m_dma, m_done, m_err, m_ovf, m_irq;
  int unsigned m_total, m_cur, m_acc;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete();
      m_en = 0; m_rst = 0; m_dma = 0; m_done = 0; m_err = 0; m_ovf = 0; m_irq = 0;
      m_total = 0; m_cur = 0; m_acc = 0;
    end else begin
      bit cw, pop;
      int sz;
      cw  = bus_wr && bus_addr == 14'h40;
      sz  = q.size();
      pop = m_en && sz > 0 && m_cur < m_total && tgt_ready && !cw;
      if (m_en && !cw && tgt_err) begin m_err = 1; m_irq = 1; end
      if (m_en && !cw && !m_rst && m_cur == m_total && tgt_done) begin m_done = 1; m_irq = 1; end
      if (m_rst) m_done = 0;
      if (pop) begin void'(q.pop_front()); m_cur += 4; end
      if (bus_wr && bus_addr == 14'h3000 && m_en) begin
        if (sz < DEPTH) begin q.push_back(bus_wdata); m_acc += 4; end
        else begin m_ovf = 1; m_irq = 1; end
      end
      if (bus_wr && bus_addr == 14'h50 && !m_en) m_total = bus_wdata;
      if (cw) begin
        if (bus_wdata[0] && !m_en) begin m_cur = 0; m_acc = 0; m_err = 0; m_ovf = 0; m_done = 0; end
        if (bus_wdata[2:0] == 0) m_irq = 0;
        if (!bus_wdata[0]) q.delete();
        m_en = bus_wdata[0]; m_rst = bus_wdata[1]; m_dma = bus_wdata[2];
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    bit mv, mreq;
    mv   = m_en && q.size() > 0 && m_cur < m_total;
    mreq = m_en && m_dma && (DEPTH - q.size() >= DEPTH / 2) && m_acc < m_total;
    check("R3 tgt_valid", tgt_valid, mv);
    if (mv) check("R3 tgt_data order", tgt_data, q[0]);
    check("R10 dma_req", dma_req, mreq);
    check("R6/R7/R8 irq", irq, m_irq);
    check("R9 tgt_cfg_n", tgt_cfg_n, !m_rst);
  end

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk); bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic expect_reg(string req, logic [AW-1:0] a, logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; idle(1);
    expect_reg("R1 ctrl", 14'h40, 0);
    expect_reg("R1 status", 14'h44, 0);
    expect_reg("R1 size", 14'h48, DEPTH * 4);
    expect_reg("R1 used", 14'h4C, 0);
    check("R1 cfg_n", tgt_cfg_n, 1);

    wr(14'h3000, 32'hDEAD0001);
    expect_reg("R2 used after idle push", 14'h4C, 0);
    check("R2 no valid", tgt_valid, 0);

    wr(14'h50, 24);
    expect_reg("R4 total loaded", 14'h50, 24);
    wr(14'h40, 1);
    wr(14'h50, 100);
    expect_reg("R4 total locked", 14'h50, 24);

    for (int i = 0; i < 6; i++) wr(14'h3000, 32'hA5000000 + i);
    expect_reg("R5 used bytes", 14'h4C, 24);
    @(negedge clk); tgt_ready = 1;
    idle(10); tgt_ready = 0;
    expect_reg("R3 cur count", 14'h54, 24);
    wr(14'h3000, 32'h0BAD0BAD);
    idle(1); tgt_ready = 1; idle(2); tgt_ready = 0;
    expect_reg("R3 held at total", 14'h4C, 4);
    check("R3 valid low at total", tgt_valid, 0);

    @(negedge clk); tgt_done = 1;
    @(negedge clk); tgt_done = 0;
    check("R6 irq", irq, 1);
    expect_reg("R6 done status", 14'h44, 32'h0004_0001);
    wr(14'h40, 0);
    check("R8 irq cleared", irq, 0);
    expect_reg("R8 flushed", 14'h4C, 0);

    wr(14'h40, 3);
    check("R9 cfg_n low", tgt_cfg_n, 0);
    expect_reg("R9 done cleared", 14'h44, 32'h1);
    wr(14'h40, 0);
    check("R9 cfg_n high", tgt_cfg_n, 1);

    wr(14'h50, 1000);
    wr(14'h40, 1);
    for (int i = 0; i < DEPTH + 1; i++) wr(14'h3000, 32'h11110000 + i);
    expect_reg("R5 overflow flag", 14'h44, 32'h5);
    expect_reg("R5 full level", 14'h4C, DEPTH * 4);
    check("R5 irq", irq, 1);
    wr(14'h40, 0);

    wr(14'h40, 1);
    @(negedge clk); tgt_err = 1;
    @(negedge clk); tgt_err = 0;
    expect_reg("R7 error flag", 14'h44, 32'h3);
    check("R7 irq", irq, 1);
    wr(14'h40, 0);
    wr(14'h40, 1);
    expect_reg("R11 flags cleared", 14'h44, 32'h1);
    expect_reg("R11 cur cleared", 14'h54, 0);
    wr(14'h40, 0);

    wr(14'h50, 64);
    wr(14'h40, 5);
    check("R10 req on", dma_req, 1);
    for (int i = 0; i < DEPTH / 2 + 1; i++) wr(14'h3000, 32'h22220000 + i);
    check("R10 req off, space", dma_req, 0);
    @(negedge clk); tgt_ready = 1;
    idle(DEPTH + 4); tgt_ready = 0;
    check("R10 req back", dma_req, 1);
    for (int i = 0; i < 7; i++) wr(14'h3000, 32'h33330000 + i);
    check("R10 req off, total", dma_req, 0);
    expect_reg("R10 level", 14'h4C, 28);
    wr(14'h40, 0);
    idle(2);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule